// File: doc/BRIEF.md
# Gated-Trigger Non-Retriggerable Pulse Generator

This block turns slow, asynchronous control levels into a clean, clock-aligned pulse whose length is counted in clock cycles. Each channel watches three control lines: a low-going trigger, a high-going trigger and an active-low hold. The low-going trigger line starts a pulse when it falls while the high-going line is high. The high-going line starts a pulse when it rises while the low-going line is low. The hold line forces the output idle while it is low. Its release can also start a pulse if the high-going line rose during the hold and both trigger lines are still in their qualifying states.

While a pulse is running, every further edge on any control line is ignored until the pulse ends, so the block cannot be retriggered. The pulse length is read from a per-channel length input at the moment a trigger is accepted. Each channel has a true output and its complement. The number of channels is a parameter, and the channels are fully independent.

Top module: `oneshot_gated`

## Requirements
- R1: With the hold line and the high-going trigger line both high, a high-to-low change on the low-going trigger line starts a pulse.
- R2: With the hold line high and the low-going trigger line low, a low-to-high change on the high-going trigger line starts a pulse.
- R3: While the hold line is low, the output is low and its complement is high, whatever the trigger lines do.
- R4: Driving the hold line low during a pulse ends that pulse before its programmed length.
- R5: A low-to-high change on the hold line starts a pulse only if the high-going trigger line rose while the hold line was low, and, at the release, the low-going trigger line is low and the high-going trigger line is high. Without that rise during the hold, the release starts nothing.
- R6: A pulse is high for exactly max(L,1) clock cycles, where L is the channel's length input. The output first goes high after the third rising clock edge that follows the input change. Two of those edges are synchroniser stages and one is the edge-detect register.
- R7: The length is captured when the trigger is accepted. Changing the length input during a pulse does not alter that pulse.
- R8: Qualifying edges that arrive while the output is high, including the clock cycle in which it falls, are ignored. They do not stretch the pulse, shorten it or queue a new one.
- R9: The complement output is always the inverse of the true output.
- R10: After reset the output is low. Steady levels on the trigger lines never start a pulse.
- R11: A qualifying edge that is detected in the first cycle after the output returns low is accepted. The output is then low for exactly one cycle between the two pulses.
- R12: Channels are independent. Activity on one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fall_trig_n | input | NUM_CH | Low-going trigger line per channel, asynchronous |
| rise_trig | input | NUM_CH | High-going trigger line per channel, asynchronous |
| hold_n | input | NUM_CH | Active-low hold/terminate line per channel, asynchronous |
| pulse_len | input | NUM_CH*LEN_W | Pulse length in cycles; channel i uses bits [i*LEN_W +: LEN_W] |
| pulse_out | output | NUM_CH | Pulse output per channel |
| pulse_out_n | output | NUM_CH | Complement of pulse_out |

## Verification
The bench builds the block with two channels and a 5-bit length input. This reaches a length of zero, short lengths where the gap before retriggering is one cycle, and lengths long enough to cut a pulse short with the hold line. The second channel shows that the channels are independent while the first one is quiet. The retrigger window is probed one cycle too early and exactly on time, so the boundary where the block becomes non-retriggerable is pinned from both sides.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronised control levels of one channel
    typedef struct packed {
        logic fall_n;   // low-going trigger line
        logic rise;     // high-going trigger line
        logic hold_n;   // active-low hold / terminate
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{fall_n: 1'b1, rise: 1'b0, hold_n: 1'b1};

    // Which path qualified the start request
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_FALL    = 2'd1,
        CAUSE_RISE    = 2'd2,
        CAUSE_RELEASE = 2'd3
    } cause_e;

    // Length saturated so that zero behaves as one cycle
    function automatic logic [15:0] sat_len(input logic [15:0] raw);
        return (raw == 16'd0) ? 16'd1 : raw;
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t d,
    output ctl_t q
);
    ctl_t stage1;
    ctl_t stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= CTL_IDLE;
            stage2 <= CTL_IDLE;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/oneshot_qualify.sv
module oneshot_qualify
    import oneshot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   cur,
    output cause_e cause,
    output logic   hold_low
);
    ctl_t prev;
    logic armed;       // high-going line rose while hold was low
    logic fall_hit;
    logic rise_hit;
    logic rel_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= CTL_IDLE;
            armed <= 1'b0;
        end else begin
            prev <= cur;
            if (!cur.hold_n)
                armed <= cur.rise & (armed | ~prev.rise);
            else
                armed <= 1'b0;
        end
    end

    always_comb begin
        fall_hit = prev.fall_n & ~cur.fall_n & cur.rise & cur.hold_n;
        rise_hit = ~prev.rise & cur.rise & ~cur.fall_n & cur.hold_n;
        rel_hit  = ~prev.hold_n & cur.hold_n & ~cur.fall_n & cur.rise & armed;
        if (fall_hit)      cause = CAUSE_FALL;
        else if (rise_hit) cause = CAUSE_RISE;
        else if (rel_hit)  cause = CAUSE_RELEASE;
        else               cause = CAUSE_NONE;
    end

    assign hold_low = ~cur.hold_n;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cause_e           cause,
    input  logic             hold_low,
    input  logic [LEN_W-1:0] len,
    output logic             accept,
    output logic             pulse
);
    logic             busy;
    logic [LEN_W-1:0] remain;
    logic [15:0]      len_ext;
    logic [15:0]      len_sat;

    always_comb begin
        len_ext = 16'(len);
        len_sat = sat_len(len_ext);
        accept  = (cause != CAUSE_NONE) & ~busy & ~hold_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (hold_low) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (accept) begin
            busy   <= 1'b1;
            remain <= LEN_W'(len_sat - 16'd1);
        end
    end

    assign pulse = busy;
endmodule

// File: rtl/oneshot_gated.sv
module oneshot_gated
    import oneshot_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int LEN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       fall_trig_n,
    input  logic [NUM_CH-1:0]       rise_trig,
    input  logic [NUM_CH-1:0]       hold_n,
    input  logic [NUM_CH*LEN_W-1:0] pulse_len,
    output logic [NUM_CH-1:0]       pulse_out,
    output logic [NUM_CH-1:0]       pulse_out_n
);
    logic [NUM_CH-1:0] hold_low_vec;
    logic [NUM_CH-1:0] trig_vec;
    logic [NUM_CH-1:0] accept_vec;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ctl_t   raw;
        ctl_t   synced;
        cause_e cause;

        assign raw = '{fall_n: fall_trig_n[i], rise: rise_trig[i], hold_n: hold_n[i]};

        oneshot_sync u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw),
            .q   (synced)
        );

        oneshot_qualify u_qual (
            .clk      (clk),
            .rst      (rst),
            .cur      (synced),
            .cause    (cause),
            .hold_low (hold_low_vec[i])
        );

        oneshot_timer #(.LEN_W(LEN_W)) u_timer (
            .clk      (clk),
            .rst      (rst),
            .cause    (cause),
            .hold_low (hold_low_vec[i]),
            .len      (pulse_len[i*LEN_W +: LEN_W]),
            .accept   (accept_vec[i]),
            .pulse    (pulse_out[i])
        );

        assign trig_vec[i]    = (cause != CAUSE_NONE);
        assign pulse_out_n[i] = ~pulse_out[i];
    end
endmodule

// File: rtl/oneshot_gated_chk.sv
module oneshot_gated_chk #(
    parameter int NUM_CH = 2,
    parameter int LEN_W  = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       hold_low,
    input logic [NUM_CH-1:0]       trig,
    input logic [NUM_CH-1:0]       accept,
    input logic [NUM_CH*LEN_W-1:0] pulse_len,
    input logic [NUM_CH-1:0]       pulse_out
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [LEN_W:0] exp_len;
        logic [LEN_W:0] run_cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                exp_len <= '0;
                run_cnt <= '0;
            end else begin
                if (accept[i])
                    exp_len <= (pulse_len[i*LEN_W +: LEN_W] == '0) ? (LEN_W+1)'(1)
                                                                   : {1'b0, pulse_len[i*LEN_W +: LEN_W]};
                run_cnt <= pulse_out[i] ? run_cnt + 1'b1 : '0;
            end
        end

        AST_HOLD_FORCES_IDLE: assert property (@(posedge clk) disable iff (rst)
            hold_low[i] |=> !pulse_out[i]); // R3

        AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_out[i]) |-> $past(trig[i])); // R10

        AST_START_NEEDS_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_out[i]) |-> $past(!hold_low[i])); // R4

        AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
            pulse_out[i] |-> (run_cnt < exp_len)); // R6
    end
endmodule

bind oneshot_gated oneshot_gated_chk #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold_low  (hold_low_vec),
    .trig      (trig_vec),
    .accept    (accept_vec),
    .pulse_len (pulse_len),
    .pulse_out (pulse_out)
);

// File: tb/oneshot_gated_test.sv
module oneshot_gated_test;
    localparam int NCH = 2;
    localparam int LW  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    fa  = '1;
    logic [NCH-1:0]    rb  = '0;
    logic [NCH-1:0]    hn  = '1;
    logic [NCH*LW-1:0] lens = '0;
    logic [NCH-1:0]    q;
    logic [NCH-1:0]    qn;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    oneshot_gated #(.NUM_CH(NCH), .LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .fall_trig_n(fa), .rise_trig(rb), .hold_n(hn),
        .pulse_len(lens), .pulse_out(q), .pulse_out_n(qn)
    );

    // ---------------- behavioural reference ----------------
    // Per channel: history of the driven levels, last three edges.
    int hist_a[NCH][3];
    int hist_b[NCH][3];
    int hist_c[NCH][3];
    int m_busy[NCH];
    int m_left[NCH];
    int m_arm[NCH];

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                for (int k = 0; k < 3; k++) begin
                    hist_a[c][k] = 1; hist_b[c][k] = 0; hist_c[c][k] = 1;
                end
                m_busy[c] = 0; m_left[c] = 0; m_arm[c] = 0;
            end else begin
                int a_now, b_now, c_now, a_old, b_old, c_old, hit, want;
                a_now = hist_a[c][1]; b_now = hist_b[c][1]; c_now = hist_c[c][1];
                a_old = hist_a[c][2]; b_old = hist_b[c][2]; c_old = hist_c[c][2];
                hit = 0;
                if (c_now == 1 && a_old == 1 && a_now == 0 && b_now == 1) hit = 1;
                if (c_now == 1 && b_old == 0 && b_now == 1 && a_now == 0) hit = 1;
                if (c_old == 0 && c_now == 1 && a_now == 0 && b_now == 1 && m_arm[c] == 1) hit = 1;
                if (c_now == 0) begin
                    m_busy[c] = 0;
                end else if (m_busy[c] == 1) begin
                    if (m_left[c] == 0) m_busy[c] = 0;
                    else m_left[c] = m_left[c] - 1;
                end else if (hit == 1) begin
                    want = int'(lens[c*LW +: LW]);
                    if (want == 0) want = 1;
                    m_busy[c] = 1;
                    m_left[c] = want - 1;
                end
                if (c_now == 0) m_arm[c] = (b_now == 1 && (m_arm[c] == 1 || b_old == 0)) ? 1 : 0;
                else            m_arm[c] = 0;
                for (int k = 2; k > 0; k--) begin
                    hist_a[c][k] = hist_a[c][k-1];
                    hist_b[c][k] = hist_b[c][k-1];
                    hist_c[c][k] = hist_c[c][k-1];
                end
                hist_a[c][0] = int'(fa[c]); hist_b[c][0] = int'(rb[c]); hist_c[c][0] = int'(hn[c]);
            end
        end
    end

    // ---------------- port monitor ----------------
    int rises[NCH];
    int cur_len[NCH];
    int last_len[NCH];
    logic [NCH-1:0] q_prev = '0;

    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (q[c] !== m_busy[c][0] || qn[c] !== ~q[c]) begin
                    failures++;
                    $display("FAIL R6/R9 ch%0d t=%0t: q=%b qn=%b expected q=%0d qn=%0d",
                             c, $time, q[c], qn[c], m_busy[c], 1 - m_busy[c]);
                end
                if (q[c] && !q_prev[c]) begin rises[c]++; cur_len[c] = 1; end
                else if (q[c]) cur_len[c]++;
                if (!q[c] && q_prev[c]) last_len[c] = cur_len[c];
            end
            q_prev = q;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_len(input int c, input int v);
        lens[c*LW +: LW] = LW'(v);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin rises[c] = 0; cur_len[c] = 0; last_len[c] = 0; end
        step(4);
        rst = 1'b0;
        step(1);
        chk("R10 reset q", int'(q[0]), 0);
        chk("R10 reset qn", int'(qn[0]), 1);

        // R1: fall on the low-going line with high-going line high
        set_len(0, 5);
        rb[0] = 1'b1; step(6);
        chk("R10 steady levels no pulse", rises[0], 0);
        fa[0] = 1'b0; step(20);
        chk("R1 pulse count", rises[0], 1);
        chk("R1/R6 length 5", last_len[0], 5);

        // R2: rise on the high-going line with low-going line low
        rb[0] = 1'b0; step(6);
        rb[0] = 1'b1; step(20);
        chk("R2 pulse count", rises[0], 2);
        chk("R2 length", last_len[0], 5);
        step(20);
        chk("R10 steady after pulse", rises[0], 2);

        // R6: zero length behaves as one
        set_len(0, 0);
        fa[0] = 1'b1; step(6);
        fa[0] = 1'b0; step(15);
        chk("R6 zero length", last_len[0], 1);
        chk("R6 zero count", rises[0], 3);

        // R7: length change during pulse ignored
        set_len(0, 6);
        fa[0] = 1'b1; step(6);
        fa[0] = 1'b0; step(4);
        set_len(0, 2); step(20);
        chk("R7 captured length", last_len[0], 6);

        // R8: edges during a pulse ignored
        set_len(0, 12);
        fa[0] = 1'b1; step(6);
        fa[0] = 1'b0; step(4);
        fa[0] = 1'b1; step(3);
        fa[0] = 1'b0; step(30);
        chk("R8 no retrigger count", rises[0], 5);
        chk("R8 length kept", last_len[0], 12);

        // R4/R3: hold cuts a pulse and blocks triggers
        set_len(0, 20);
        fa[0] = 1'b1; step(6);
        fa[0] = 1'b0; step(8);
        hn[0] = 1'b0; step(6);
        chk("R4 pulse cut", last_len[0] < 20 ? 1 : 0, 1);
        chk("R3 q low in hold", int'(q[0]), 0);
        chk("R3 qn high in hold", int'(qn[0]), 1);
        fa[0] = 1'b1; step(4);
        fa[0] = 1'b0; step(8);
        chk("R3 trigger ignored in hold", rises[0], 6);

        // R5 negative: release without a rise during hold
        set_len(0, 4);
        hn[0] = 1'b1; step(10);
        chk("R5 no arm no pulse", rises[0], 6);

        // R5 positive: rise during hold, then release
        hn[0] = 1'b0; rb[0] = 1'b0; step(5);
        rb[0] = 1'b1; step(5);
        chk("R3 rise in hold no pulse", rises[0], 6);
        hn[0] = 1'b1; step(15);
        chk("R5 release pulse", rises[0], 7);
        chk("R5 release length", last_len[0], 4);

        // R11/R8: retrigger window, one cycle early is ignored
        set_len(0, 3);
        rb[0] = 1'b0; step(6);
        rb[0] = 1'b1; step(1);
        rb[0] = 1'b0; step(2);
        rb[0] = 1'b1; step(15);
        chk("R8 early edge ignored", rises[0], 8);

        // R11: on-time edge accepted right after the pulse ends
        rb[0] = 1'b0; step(6);
        rb[0] = 1'b1; step(1);
        rb[0] = 1'b0; step(3);
        rb[0] = 1'b1; step(15);
        chk("R11 back-to-back pulse", rises[0], 10);
        chk("R11 second length", last_len[0], 3);

        // R12: channel 1 alone
        set_len(1, 4);
        rb[1] = 1'b1; step(4);
        fa[1] = 1'b0; step(15);
        chk("R12 ch1 pulse", rises[1], 1);
        chk("R12 ch1 length", last_len[1], 4);
        chk("R12 ch0 untouched", rises[0], 10);

        step(5);
        summary();
        $finish;
    end
endmodule